// File: doc/BRIEF.md
# Serial Mode-Register Receiver

This block receives configuration commands over a three-wire serial link (active-low select, serial clock, serial data) and turns them into a handful of registered mode controls for a data-converter control unit. While the select line is low, each falling edge of the serial clock shifts one data bit in. Every sixteen bits form a command word: a 4-bit address in the top bits, followed by a 12-bit data field.

A complete word is decoded on the same falling edge that delivers its last bit. Three addresses are recognised. Each one updates a single mode field: the delay-locked-loop disable, the 2-bit output test-pattern select, or the power-down control. A select window may carry any number of back-to-back words. Bits left over at the end of a window never reach a register. The serial inputs are sampled by the block clock, which must run at least twice as fast as the serial clock. The mode outputs come straight from flops.

Top module: `cfg_serial_port`

## Requirements
- R1: While `rst` is high at a `clk` edge, the block sets `dll_off`=0, `test_sel`=2'b00 and `pwr_down`=0. These values hold until a valid word changes them.
- R2: A bit is taken only on a falling edge of `sclk` (seen as 1 then 0 on successive `clk` edges) while `sen_n` is low. Toggling `sclk` with `sen_n` high changes no output.
- R3: Words are sent MSB first, address bits A3..A0 first, then D11..D0. A word with address 4'b1101 loads D1 into `dll_off` (1 = loop disabled).
- R4: A word with address 4'b1110 loads D9 into `test_sel[1]` and D8 into `test_sel[0]`.
- R5: A word with address 4'b1111 loads D11 into `pwr_down` (1 = low-current mode).
- R6: Outputs change only on the 16th falling edge of a word, counted from the start of the select window. After 15 edges every output still holds its old value.
- R7: Consecutive 16-bit words inside one select-low window are each decoded in turn. A later word to the same address overrides the earlier one.
- R8: When `sen_n` goes high, any partial word is discarded and changes no register. The next window starts framing at bit 0.
- R9: A complete word whose address is none of 1101, 1110 or 1111 changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the serial inputs |
| rst | input | 1 | Synchronous reset, active high |
| sen_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdata | input | 1 | Serial data, MSB first |
| dll_off | output | 1 | Delay-locked-loop disable |
| test_sel | output | 2 | Output test-pattern select |
| pwr_down | output | 1 | Power-down request |

## Verification
Directed windows check the basic behaviour:
- A single word to each defined address shows that each field lands in its own bit position, and that no other field moves.
- A 15-bit window followed by a 16th edge separates "commit on the last bit" from commit on any earlier bit. It also exposes a counter that is off by one.
- Windows carrying several words, or ending in a partial tail, separate correct re-framing inside a window from framing that drifts or leaks the tail.
- Clock toggles with select high, and words sent to undefined addresses, confirm that neither one disturbs the stored modes.

Randomised windows then mix word counts, addresses, data values and tail lengths. After each window the outputs are compared with a bench model of the mode registers.

// File: rtl/cfg_serial_port.sv
module cfg_serial_port #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 12,
  parameter logic [ADDR_W-1:0] DLL_ADDR = 4'b1101,
  parameter logic [ADDR_W-1:0] TP_ADDR  = 4'b1110,
  parameter logic [ADDR_W-1:0] PD_ADDR  = 4'b1111,
  parameter int DLL_BIT = 1,
  parameter int TP_LSB  = 8,
  parameter int PD_BIT  = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sen_n,
  input  logic       sclk,
  input  logic       sdata,
  output logic       dll_off,
  output logic [1:0] test_sel,
  output logic       pwr_down
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-2:0] shreg;

  wire               take  = sclk_q & ~sclk & ~sen_n;
  wire               last  = (bit_cnt == LAST);
  wire [WORD_W-1:0]  word  = {shreg, sdata};
  wire [ADDR_W-1:0]  waddr = word[WORD_W-1 -: ADDR_W];
  wire [DATA_W-1:0]  wdata = word[DATA_W-1:0];
  wire               commit = take & last;

  always_ff @(posedge clk) begin
    sclk_q <= sclk;
    if (rst) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      dll_off  <= 1'b0;
      test_sel <= 2'b00;
      pwr_down <= 1'b0;
    end else if (sen_n) begin
      bit_cnt <= '0;
    end else if (take) begin
      shreg   <= word[WORD_W-2:0];
      bit_cnt <= last ? '0 : bit_cnt + CNT_W'(1);
      if (commit) begin
        if (waddr == DLL_ADDR) dll_off  <= wdata[DLL_BIT];
        if (waddr == TP_ADDR)  test_sel <= wdata[TP_LSB +: 2];
        if (waddr == PD_ADDR)  pwr_down <= wdata[PD_BIT];
      end
    end
  end
endmodule

module cfg_serial_port_chk #(
  parameter int CNT_W = 4,
  parameter int LAST  = 15
) (
  input logic             clk,
  input logic             rst,
  input logic             sen_n,
  input logic             sclk,
  input logic             sclk_q,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             dll_off,
  input logic [1:0]       test_sel,
  input logic             pwr_down
);
  wire       fall = sclk_q & ~sclk;
  wire [3:0] modes = {pwr_down, test_sel, dll_off};

  p_reset_defaults_r1: assert property (@(posedge clk)
    rst |=> (modes == 4'b0000));

  p_idle_select_r2: assert property (@(posedge clk) disable iff (rst)
    sen_n |=> $stable(modes));

  p_no_edge_no_change_r2: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(modes));

  p_commit_last_bit_r6: assert property (@(posedge clk) disable iff (rst)
    !(fall && !sen_n && bit_cnt == CNT_W'(LAST)) |=> $stable(modes));

  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    (fall && !sen_n) |=>
      (bit_cnt == (($past(bit_cnt) == CNT_W'(LAST)) ? '0 : CNT_W'($past(bit_cnt) + 1'b1))));

  p_window_reframe_r8: assert property (@(posedge clk) disable iff (rst)
    sen_n |=> (bit_cnt == '0));
endmodule

bind cfg_serial_port cfg_serial_port_chk #(.CNT_W(CNT_W), .LAST(WORD_W - 1)) u_chk (
  .clk(clk), .rst(rst), .sen_n(sen_n), .sclk(sclk), .sclk_q(sclk_q),
  .bit_cnt(bit_cnt), .dll_off(dll_off), .test_sel(test_sel), .pwr_down(pwr_down)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sen_n = 1'b1;
  logic sclk = 1'b1;
  logic sdata = 1'b0;
  logic dll_off, pwr_down;
  logic [1:0] test_sel;

  int n_chk = 0;
  int n_bad = 0;

  logic       m_dll = 1'b0;
  logic [1:0] m_tp  = 2'b00;
  logic       m_pd  = 1'b0;

  cfg_serial_port u_dut (
    .clk(clk), .rst(rst), .sen_n(sen_n), .sclk(sclk), .sdata(sdata),
    .dll_off(dll_off), .test_sel(test_sel), .pwr_down(pwr_down)
  );

  always #2 clk = ~clk;

  function automatic logic [3:0] model_modes();
    return {m_pd, m_tp, m_dll};
  endfunction

  function automatic void model_apply(input logic [15:0] w);
    case (w[15:12])
      4'b1101: m_dll = w[1];
      4'b1110: m_tp  = w[9:8];
      4'b1111: m_pd  = w[11];
      default: ;
    endcase
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {pwr_down, test_sel, dll_off};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: modes got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sclk = 1'b1; sdata = b; idle(2);
    sclk = 1'b0; idle(2);
    sclk = 1'b1;
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) send_bit(w[i]);
  endtask

  task automatic open_win();
    sen_n = 1'b0; idle(2);
  endtask

  task automatic close_win();
    idle(2); sen_n = 1'b1; idle(3);
  endtask

  task automatic word_win(input logic [15:0] w);
    open_win(); send_bits(w, 16); model_apply(w); close_win();
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    idle(4);
    check("R1 reset", 4'b0000);
    rst = 1'b0; idle(2);
    check("R1 after release", 4'b0000);

    word_win(16'hD002);
    check("R3 dll_off set", model_modes());
    word_win(16'hE300);
    check("R4 test_sel 11", model_modes());
    word_win(16'hE100);
    check("R4 test_sel 01", model_modes());
    word_win(16'hF800);
    check("R5 power down", model_modes());

    for (int i = 0; i < 40; i++) begin
      sclk = ~sclk; sdata = ~sdata; idle(2);
    end
    sclk = 1'b1; idle(2);
    check("R2 sclk toggles with select high", model_modes());

    open_win(); send_bits(16'hD000, 15); idle(2);
    check("R6 no change after 15 edges", model_modes());
    send_bit(1'b0); model_apply(16'hD000); idle(2);
    check("R6 change on 16th edge", model_modes());
    close_win();

    open_win();
    send_bits(16'hE200, 16); model_apply(16'hE200);
    send_bits(16'hF000, 16); model_apply(16'hF000);
    send_bits(16'hE000, 16); model_apply(16'hE000);
    close_win();
    check("R7 three words in one window", model_modes());

    open_win(); send_bits(16'hD002, 16); model_apply(16'hD002);
    send_bits(16'hF800, 12); close_win();
    check("R8 partial tail dropped", model_modes());
    word_win(16'hE100);
    check("R8 framing restarts at bit 0", model_modes());

    word_win(16'h0FFF);
    check("R9 address 0000 ignored", model_modes());
    word_win(16'hCFFF);
    check("R9 address 1100 ignored", model_modes());

    for (int it = 0; it < 150; it++) begin
      int nw;
      int tail;
      logic [15:0] w;
      nw = int'($urandom % 3) + 1;
      open_win();
      for (int k = 0; k < nw; k++) begin
        w[11:0] = 12'($urandom);
        if ($urandom % 4 == 0) w[15:12] = 4'($urandom);
        else w[15:12] = 4'(13 + ($urandom % 3));
        send_bits(w, 16); model_apply(w);
      end
      tail = int'($urandom % 16);
      if (tail > 0) send_bits(16'($urandom), tail);
      close_win();
      check("R7 R8 R9 random window", model_modes());
    end

    rst = 1'b1; idle(2); rst = 1'b0;
    m_dll = 1'b0; m_tp = 2'b00; m_pd = 1'b0;
    idle(1);
    check("R1 reset mid-run", 4'b0000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule